// File: doc/BRIEF.md
# Dual Chainable Timer/Counter

This block holds two up-counters with a shared block-level control space behind a simple synchronous register bus. Each channel takes commands to enable its count clock, to disable it, or to restart it from zero. It has a selectable prescaler and an optional compare register that makes the counter restart. It also holds two spare compare registers, a status register that clears when read, and interrupt enables that are changed through separate set and clear registers. Each channel drives its own interrupt line.

A block-level mode bit chains the two channels. Channel 1 then counts the wraps of channel 0, which gives a time base twice the counter width. Software reads channel 1 for the upper half and channel 0 for the lower half. A block-level sync command restarts both channels in the same clock, so the two halves start aligned.

Address map: `bus_addr[5:4]` selects channel 0 (0), channel 1 (1) or the block registers (2). `bus_addr[3:0]` is the offset within that space. Read data is combinational from the address in the cycle that `bus_rd` is high. Register side effects take place on the clock edge that ends the access.

Top module: `tmr_pair`

## Requirements
- R1: Offset 0 is a write-only command register: bit0 enables the clock, bit1 disables it, bit2 is a software trigger. A trigger sets the counter (read at offset 5) to 0. An enabled channel then advances by one on each count tick.
- R2: Mode register offset 1, bits[1:0] select the count tick: value s advances the counter once every 2^s system clocks counted from the trigger (0: every clock, 1: every second clock, 2: every fourth, 3: every eighth).
- R3: When enable and disable are written together, the clock ends up disabled. A disabled channel holds its count and ignores triggers. Status bit 16 reads 1 while the clock is enabled.
- R4: With mode bit 2 set, a tick that finds the counter equal to the compare value at offset 4 sets status bit 4 and returns the counter to 0, so it cycles through compare+1 values. With mode bit 2 clear, the same match sets bit 4 and the count goes on.
- R5: Reading status at offset 6 returns the event flags (bit0 counter wrap from all ones to 0, bit4 compare match) and clears them. An event that occurs in the same cycle as the read is kept.
- R6: Writing 1s to offset 7 sets interrupt mask bits and writing 1s to offset 8 clears them (only bits 0 and 4 exist). Offset 9 reads the current mask. Writing 0xFF to offset 8 clears every mask bit.
- R7: Interrupt output `irq[n]` is high whenever a status flag of channel n and its mask bit are both set.
- R8: Offsets 2 and 3 are compare registers that read back what was written and have no effect on counting.
- R9: Writing bit0 of block offset 0 (address 0x20) triggers both channels in the same cycle.
- R10: Block offset 1 (address 0x21) bit0 enables chaining. Channel 1 then advances once per wrap of channel 0 and ignores its own tick select, so channel 1 holds the upper half of the combined count.
- R11: After reset the clocks are disabled, counters, compare registers, flags and masks are 0, chaining is off and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on read) |
| bus_addr | input | 6 | Register address: space in [5:4], offset in [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
The bench sweeps each prescaler setting with and without compare restart, including a compare value of 0. A design that miscounts prescaler phase after a trigger, or restarts one tick late, reads back a count that is off by one. The bench writes enable and disable together and triggers a stopped channel, which catches a design that gives enable priority or lets triggers through while the clock is off. It reads status twice in a row and after a mask clear, which exposes flags that fail to clear or an interrupt that lingers. It also runs the chained count across a full lower-half wrap and reads the two halves one cycle apart, so a carry that lands in the wrong cycle or a chained channel that still obeys its own prescaler shows up as a wrong upper half.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DATA_W = 32;
   localparam int N_CH   = 2;
   localparam int CLKON_BIT = 16;

   typedef enum logic [3:0] {
      OFF_CMD  = 4'd0,
      OFF_MODE = 4'd1,
      OFF_CA   = 4'd2,
      OFF_CB   = 4'd3,
      OFF_CMP  = 4'd4,
      OFF_CNT  = 4'd5,
      OFF_STAT = 4'd6,
      OFF_MSET = 4'd7,
      OFF_MCLR = 4'd8,
      OFF_MASK = 4'd9
   } ch_off_e;

   localparam logic [1:0] SPACE_BLK = 2'd2;
   localparam logic [3:0] BLK_SYNC  = 4'd0;
   localparam logic [3:0] BLK_MODE  = 4'd1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PW = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("tmr_prescale: SEL_W must be 1..3");
   end

   logic [PW-1:0] phase;
   logic [PW-1:0] low_mask;

   for (genvar i = 0; i < PW; i++) begin : g_mask
      assign low_mask[i] = (int'(sel) > i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      phase <= '0;
      else if (clear)  phase <= '0;
      else if (run)    phase <= phase + 1'b1;
   end

   assign tick = &(phase | ~low_mask);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int SEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_stat,
   input  logic [3:0]        off,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              sync_trig,
   input  logic              chain_mode,
   input  logic              chain_tick,
   output logic [DATA_W-1:0] rdata,
   output logic              wrap_evt,
   output logic              irq
);
   if (CNT_W < 8 || CNT_W > CLKON_BIT) begin : g_bad_w
      $error("tmr_channel: CNT_W must be 8..16");
   end

   logic [SEL_W-1:0] mode_sel;
   logic             mode_rst;
   logic [CNT_W-1:0] cmp_a, cmp_b, cmp_r, cnt;
   logic             clken, clken_nxt;
   logic             flag_wrap, flag_cmp;
   logic             mask_wrap, mask_cmp;
   logic             cmd_wr, trig, pre_tick, tick, advance, cmp_hit, restart;

   assign cmd_wr = wr_en && (off == OFF_CMD);

   always_comb begin
      clken_nxt = clken;
      if (cmd_wr) begin
         if (wdata[1])      clken_nxt = 1'b0;
         else if (wdata[0]) clken_nxt = 1'b1;
      end
   end

   assign trig = clken_nxt && ((cmd_wr && wdata[2]) || sync_trig);

   tmr_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (clken),
      .clear (trig),
      .sel   (mode_sel),
      .tick  (pre_tick)
   );

   assign tick     = chain_mode ? chain_tick : pre_tick;
   assign advance  = clken && tick && !trig;
   assign cmp_hit  = advance && (cnt == cmp_r);
   assign restart  = cmp_hit && mode_rst;
   assign wrap_evt = advance && (&cnt) && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clken <= 1'b0;
         cnt   <= '0;
      end else begin
         clken <= clken_nxt;
         if (trig)         cnt <= '0;
         else if (restart) cnt <= '0;
         else if (advance) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_sel <= '0;
         mode_rst <= 1'b0;
         cmp_a    <= '0;
         cmp_b    <= '0;
         cmp_r    <= '0;
      end else if (wr_en) begin
         case (off)
            OFF_MODE: begin
               mode_sel <= wdata[SEL_W-1:0];
               mode_rst <= wdata[2];
            end
            OFF_CA:  cmp_a <= wdata;
            OFF_CB:  cmp_b <= wdata;
            OFF_CMP: cmp_r <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_wrap <= 1'b0;
         flag_cmp  <= 1'b0;
      end else begin
         flag_wrap <= wrap_evt | (flag_wrap & ~rd_stat);
         flag_cmp  <= cmp_hit  | (flag_cmp  & ~rd_stat);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_wrap <= 1'b0;
         mask_cmp  <= 1'b0;
      end else if (wr_en && off == OFF_MSET) begin
         mask_wrap <= mask_wrap | wdata[0];
         mask_cmp  <= mask_cmp  | wdata[4];
      end else if (wr_en && off == OFF_MCLR) begin
         mask_wrap <= mask_wrap & ~wdata[0];
         mask_cmp  <= mask_cmp  & ~wdata[4];
      end
   end

   assign irq = (flag_wrap & mask_wrap) | (flag_cmp & mask_cmp);

   always_comb begin
      rdata = '0;
      case (off)
         OFF_MODE: begin
            rdata[SEL_W-1:0] = mode_sel;
            rdata[2]         = mode_rst;
         end
         OFF_CA:   rdata = DATA_W'(cmp_a);
         OFF_CB:   rdata = DATA_W'(cmp_b);
         OFF_CMP:  rdata = DATA_W'(cmp_r);
         OFF_CNT:  rdata = DATA_W'(cnt);
         OFF_STAT: begin
            rdata[0]         = flag_wrap;
            rdata[4]         = flag_cmp;
            rdata[CLKON_BIT] = clken;
         end
         OFF_MASK: begin
            rdata[0] = mask_wrap;
            rdata[4] = mask_cmp;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int SEL_W    = 2,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [5:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CH-1:0]   irq
);
   logic [1:0]        space;
   logic [3:0]        off;
   logic              sync_trig;
   logic              chain_on;
   logic [N_CH-1:0]   wrap_v;
   logic [N_CH-1:0]   chain_mode_v;
   logic [N_CH-1:0]   chain_tick_v;
   logic [DATA_W-1:0] ch_rdata [N_CH];

   assign space     = bus_addr[5:4];
   assign off       = bus_addr[3:0];
   assign sync_trig = bus_wr && space == SPACE_BLK && off == BLK_SYNC && bus_wdata[0];

   if (CHAIN_EN) begin : g_chain
      always_ff @(posedge clk) begin
         if (!rst_n)
            chain_on <= 1'b0;
         else if (bus_wr && space == SPACE_BLK && off == BLK_MODE)
            chain_on <= bus_wdata[0];
      end
   end else begin : g_nochain
      assign chain_on = 1'b0;
   end

   assign chain_mode_v = {chain_on, 1'b0};
   assign chain_tick_v = {wrap_v[0], 1'b0};

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (bus_wr && space == 2'(ch)),
         .rd_stat    (bus_rd && space == 2'(ch) && off == OFF_STAT),
         .off        (off),
         .wdata      (bus_wdata[CNT_W-1:0]),
         .sync_trig  (sync_trig),
         .chain_mode (chain_mode_v[ch]),
         .chain_tick (chain_tick_v[ch]),
         .rdata      (ch_rdata[ch]),
         .wrap_evt   (wrap_v[ch]),
         .irq        (irq[ch])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (space)
         2'd0:      bus_rdata = ch_rdata[0];
         2'd1:      bus_rdata = ch_rdata[1];
         SPACE_BLK: bus_rdata[0] = (off == BLK_MODE) && chain_on;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic             clken,
   input logic             trig,
   input logic             advance,
   input logic             cmp_hit,
   input logic             mode_rst,
   input logic             flag_cmp,
   input logic             rd_stat,
   input logic             cmd_wr,
   input logic             dis_bit,
   input logic             clr_all,
   input logic             irq
);
   // R1
   a_r1_trig_zero: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (cnt == '0));
   // R1
   a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !(cmp_hit && mode_rst)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
   // R3
   a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!clken && !trig) |=> $stable(cnt));
   // R3
   a_r3_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dis_bit) |=> !clken);
   // R4
   a_r4_cmp_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit && mode_rst) |=> (cnt == '0 && flag_cmp));
   // R5
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !cmp_hit) |=> !flag_cmp);
   // R6
   a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> !irq);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt      (cnt),
   .clken    (clken),
   .trig     (trig),
   .advance  (advance),
   .cmp_hit  (cmp_hit),
   .mode_rst (mode_rst),
   .flag_cmp (flag_cmp),
   .rd_stat  (rd_stat),
   .cmd_wr   (cmd_wr),
   .dis_bit  (wdata[1]),
   .clr_all  (wr_en && off == tmr_pkg::OFF_MCLR && wdata[7:0] == 8'hFF),
   .irq      (irq)
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_pair u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam int NV = 8;
   localparam int V_SEL [NV] = '{0, 1, 2, 3, 0, 1, 0, 2};
   localparam int V_RST [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
   localparam int V_CMP [NV] = '{0, 100, 100, 100, 5, 3, 0, 2};
   localparam int V_WAIT[NV] = '{10, 21, 35, 80, 20, 19, 7, 40};
   localparam int V_EXP [NV] = '{10, 10, 8, 10, 2, 1, 0, 1};

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, hold;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(6'h05, v); check("R11 cnt0", v, 0);
      rd(6'h06, v); check("R11 stat0", v, 0);
      rd(6'h09, v); check("R11 mask0", v, 0);
      rd(6'h02, v); check("R11 cmpa0", v, 0);
      rd(6'h11, v); check("R11 mode1", v, 0);
      rd(6'h21, v); check("R11 chain", v, 0);
      check("R11 irq", {30'd0, irq}, 0);

      // R3 enable shows in status bit 16
      wr(6'h00, 32'h1);
      rd(6'h06, v); check("R3 clkon", (v >> 16) & 1, 1);

      // R1 R2 R4 vector sweep
      for (int i = 0; i < NV; i++) begin
         wr(6'h01, 32'(V_SEL[i] | (V_RST[i] << 2)));
         wr(6'h04, 32'(V_CMP[i]));
         wr(6'h00, 32'h4);
         repeat (V_WAIT[i]) @(negedge clk);
         rd(6'h05, v);
         check($sformatf("R2 R4 vector %0d", i), v, 32'(V_EXP[i]));
      end

      // R5 read clears, R3 disable
      wr(6'h00, 32'h2);
      rd(6'h06, v); check("R5 stat first", v & 32'h10011, 32'h10);
      rd(6'h06, v); check("R5 stat second", v, 0);

      // R3 hold and ignore trigger while off
      rd(6'h05, hold);
      repeat (5) @(negedge clk);
      rd(6'h05, v); check("R3 hold", v, hold);
      wr(6'h00, 32'h4);
      rd(6'h05, v); check("R3 trig ignored", v, hold);
      wr(6'h00, 32'h3);
      rd(6'h06, v); check("R3 disable wins", v, 0);
      rd(6'h05, v); check("R3 still held", v, hold);

      // R8 spare compares read back, no effect
      wr(6'h01, 32'h0);
      wr(6'h04, 32'hFFFF);
      wr(6'h02, 32'h3);
      wr(6'h03, 32'h7);
      rd(6'h02, v); check("R8 cmpa", v, 3);
      rd(6'h03, v); check("R8 cmpb", v, 7);
      wr(6'h00, 32'h1);
      wr(6'h00, 32'h4);
      repeat (9) @(negedge clk);
      rd(6'h05, v); check("R8 count past", v, 9);

      // R6 mask set/clear
      wr(6'h07, 32'h11);
      rd(6'h09, v); check("R6 set", v, 32'h11);
      wr(6'h08, 32'h01);
      rd(6'h09, v); check("R6 clear one", v, 32'h10);
      wr(6'h08, 32'hFF);
      rd(6'h09, v); check("R6 clear all", v, 0);

      // R7 interrupt
      wr(6'h07, 32'h10);
      wr(6'h01, 32'h4);
      wr(6'h04, 32'h5);
      wr(6'h00, 32'h4);
      repeat (10) @(negedge clk);
      #1 check("R7 irq high", {30'd0, irq}, 32'h1);
      wr(6'h00, 32'h2);
      rd(6'h06, v); check("R7 stat", v & 32'h10, 32'h10);
      #1 check("R7 irq low", {30'd0, irq}, 0);
      wr(6'h08, 32'hFF);

      // R9 sync
      wr(6'h10, 32'h1);
      wr(6'h11, 32'h0);
      wr(6'h00, 32'h1);
      wr(6'h01, 32'h0);
      wr(6'h04, 32'hFFFF);
      wr(6'h20, 32'h1);
      repeat (4) @(negedge clk);
      rd(6'h05, v); check("R9 ch0", v, 4);
      rd(6'h15, v); check("R9 ch1", v, 5);

      // R10 chain
      wr(6'h21, 32'h1);
      rd(6'h21, v); check("R10 chain rb", v, 1);
      wr(6'h11, 32'h3);
      rd(6'h06, v);
      wr(6'h20, 32'h1);
      repeat (65535) @(negedge clk);
      rd(6'h05, v); check("R10 low max", v, 32'hFFFF);
      rd(6'h15, v); check("R10 upper carry", v, 1);
      rd(6'h05, v); check("R10 low wrapped", v, 1);
      rd(6'h06, v); check("R10 wrap flag", v & 1, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule